// File: doc/BRIEF.md
# Peripheral Register Write Guard

This block sits on an 8-bit register bus between a processor and a bank of peripheral control registers. It holds one 8-bit guard control register. Three of its bits each lock one functional group of peripheral registers against writes. The groups are port configuration, interrupt configuration, and clock / supply-voltage-monitor / memory-parity-monitor control. While a group is locked, a bus write whose address falls in that group never reaches the peripherals. Every read is passed through unchanged. Each group's membership is a list of address ranges set by parameters. The port data registers fall outside every range, so they stay writable whatever the guard settings are.

Software reads and writes the guard register at its own address at any time. The register is never locked, and it is never forwarded to the peripherals. A programming-mode input keeps the clock-group lock off: the lock cannot be set while the input is high, and it is cleared if it was already set. After each suppressed write, a one-cycle blocked-write pulse appears.

Top module: `regbus_write_guard`

## Requirements
- R1: After reset the guard register reads 0x00, no group is locked, and `wr_blocked` is 0.
- R2: The guard register accepts 8-bit writes at `CTRL_ADDR`. Bits 7, 5, 4, 2, 1 and 0 read back as written. Bits 6 and 3 always read 0.
- R3: While bit 2 is 1, writes to the port group are suppressed (`periph_wr` stays 0). The port group is 0x020–0x03F and 0x060 by default.
- R4: Writes to the port data range (0x000–0x00F by default) always reach the peripherals, whatever the guard bits are.
- R5: While bit 1 is 1, writes to the interrupt group are suppressed. The interrupt group is 0x0E0–0x0EF and 0x048–0x049 by default.
- R6: While bit 0 is 1, writes to the clock/monitor group are suppressed. The clock/monitor group is 0x0A0–0x0A9 and 0x0F5 by default.
- R7: Every read of a peripheral address asserts `periph_rd` in the same cycle and returns `periph_rdata` on `cpu_rdata`, whatever the guard bits are.
- R8: The guard register is never write-protected. Accesses to `CTRL_ADDR` never assert `periph_wr` or `periph_rd`.
- R9: A suppressed write makes `wr_blocked` 1 for exactly the following cycle. Writes that are not suppressed leave it 0.
- R10: While `prog_mode` is 1, a write of 1 to bit 0 stores 0, and a stored bit 0 is cleared at the next clock edge. The other bits are unaffected.
- R11: A new guard value applies from the bus cycle right after the cycle in which it is written.
- R12: Writes that pass through present `cpu_addr` and `cpu_wdata` unchanged. Addresses outside every group are never suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_mode | input | 1 | Programming mode; keeps the clock-group lock off |
| cpu_addr | input | AW | Bus address |
| cpu_wdata | input | 8 | Bus write data |
| cpu_wr | input | 1 | Bus write strobe |
| cpu_rd | input | 1 | Bus read strobe |
| cpu_rdata | output | 8 | Read data returned to the bus |
| periph_addr | output | AW | Address forwarded to the peripherals |
| periph_wdata | output | 8 | Write data forwarded to the peripherals |
| periph_wr | output | 1 | Gated peripheral write strobe |
| periph_rd | output | 1 | Peripheral read strobe |
| periph_rdata | input | 8 | Read data from the peripherals |
| wr_blocked | output | 1 | One-cycle pulse after a suppressed write |

## Verification
Two functions can act on clock-group bit 0 in the same cycle: a software write to the guard register that sets the bit, and the programming-mode override that clears it. The bench raises `prog_mode` during the very bus cycle that writes 0x01 to the guard register. It then reads the register back and expects bit 0 to be 0. It then writes a clock-group address and expects the write to reach the peripherals with no blocked pulse. A second case sets the bit first and then holds programming mode for one cycle. That case must clear bit 0 while bits 2 and 1 stay as they were.

// File: rtl/wguard_pkg.sv
package wguard_pkg;

  localparam int DW   = 8;
  localparam int NGRP = 3;

  // guard bit positions inside the control register (also hit-vector index)
  localparam int GB_CLK  = 0;
  localparam int GB_IRQ  = 1;
  localparam int GB_PORT = 2;

  // writable bits: 7,5,4 spare storage, 2..0 group locks; 6 and 3 reserved
  localparam logic [DW-1:0] CTRL_WMASK = 8'hB7;

  typedef struct packed {
    logic spare7;
    logic rsv6;
    logic spare5;
    logic spare4;
    logic rsv3;
    logic lock_port;
    logic lock_irq;
    logic lock_clk;
  } guard_ctrl_t;

endpackage

// File: rtl/wguard_rst_sync.sv
module wguard_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/wguard_range_decode.sv
module wguard_range_decode #(
  parameter int               AW = 10,
  parameter int               NR = 1,
  parameter logic [NR*AW-1:0] LO = '0,
  parameter logic [NR*AW-1:0] HI = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);

  logic [NR-1:0] in_rng;

  for (genvar i = 0; i < NR; i++) begin : g_rng
    localparam logic [AW-1:0] RLO = LO[i*AW +: AW];
    localparam logic [AW-1:0] RHI = HI[i*AW +: AW];
    assign in_rng[i] = (addr >= RLO) && (addr <= RHI);
  end

  assign hit = |in_rng;

endmodule

// File: rtl/wguard_ctrl_reg.sv
module wguard_ctrl_reg
  import wguard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  input  logic          prog_mode,
  output guard_ctrl_t   ctl_q
);

  guard_ctrl_t ctl_d;
  logic        ctl_en;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_sel) begin
      ctl_d = guard_ctrl_t'(wdata & CTRL_WMASK);
    end
    if (prog_mode) begin
      ctl_d.lock_clk = 1'b0;
    end
  end

  assign ctl_en = wr_sel | prog_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/wguard_write_gate.sv
module wguard_write_gate
  import wguard_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic            is_ctrl,
  input  logic [NGRP-1:0] hit,
  input  logic [NGRP-1:0] lock,
  output logic            wr_out,
  output logic            rd_out,
  output logic            blk_q
);

  logic locked_hit;
  logic blk_d;
  logic blk_en;

  always_comb begin
    locked_hit = |(hit & lock);
    wr_out     = wr & ~is_ctrl & ~locked_hit;
    rd_out     = rd & ~is_ctrl;
    blk_d      = wr & ~is_ctrl & locked_hit;
    blk_en     = blk_d | blk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
    end else if (blk_en) begin
      blk_q <= blk_d;
    end
  end

endmodule

// File: rtl/regbus_write_guard.sv
module regbus_write_guard
  import wguard_pkg::*;
#(
  parameter int                 AW        = 10,
  parameter logic [AW-1:0]      CTRL_ADDR = 10'h078,
  parameter int                 PORT_NR   = 2,
  parameter logic [PORT_NR*AW-1:0] PORT_LO = {10'h060, 10'h020},
  parameter logic [PORT_NR*AW-1:0] PORT_HI = {10'h060, 10'h03F},
  parameter int                 IRQ_NR    = 2,
  parameter logic [IRQ_NR*AW-1:0]  IRQ_LO  = {10'h048, 10'h0E0},
  parameter logic [IRQ_NR*AW-1:0]  IRQ_HI  = {10'h049, 10'h0EF},
  parameter int                 CLK_NR    = 3,
  parameter logic [CLK_NR*AW-1:0]  CLK_LO  = {10'h0F5, 10'h0A8, 10'h0A0},
  parameter logic [CLK_NR*AW-1:0]  CLK_HI  = {10'h0F5, 10'h0A9, 10'h0A7}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_mode,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] periph_addr,
  output logic [DW-1:0] periph_wdata,
  output logic          periph_wr,
  output logic          periph_rd,
  input  logic [DW-1:0] periph_rdata,
  output logic          wr_blocked
);

  logic            rst_int_n;
  logic            is_ctrl;
  guard_ctrl_t     ctl_q;
  logic [NGRP-1:0] hit_vec;
  logic [NGRP-1:0] lock_vec;

  wguard_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign is_ctrl = (cpu_addr == CTRL_ADDR);

  wguard_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_sel    (cpu_wr & is_ctrl),
    .wdata     (cpu_wdata),
    .prog_mode (prog_mode),
    .ctl_q     (ctl_q)
  );

  wguard_range_decode #(.AW(AW), .NR(PORT_NR), .LO(PORT_LO), .HI(PORT_HI)) u_dec_port (
    .addr (cpu_addr),
    .hit  (hit_vec[GB_PORT])
  );

  wguard_range_decode #(.AW(AW), .NR(IRQ_NR), .LO(IRQ_LO), .HI(IRQ_HI)) u_dec_irq (
    .addr (cpu_addr),
    .hit  (hit_vec[GB_IRQ])
  );

  wguard_range_decode #(.AW(AW), .NR(CLK_NR), .LO(CLK_LO), .HI(CLK_HI)) u_dec_clk (
    .addr (cpu_addr),
    .hit  (hit_vec[GB_CLK])
  );

  always_comb begin
    lock_vec          = '0;
    lock_vec[GB_PORT] = ctl_q.lock_port;
    lock_vec[GB_IRQ]  = ctl_q.lock_irq;
    lock_vec[GB_CLK]  = ctl_q.lock_clk;
  end

  wguard_write_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (cpu_wr),
    .rd      (cpu_rd),
    .is_ctrl (is_ctrl),
    .hit     (hit_vec),
    .lock    (lock_vec),
    .wr_out  (periph_wr),
    .rd_out  (periph_rd),
    .blk_q   (wr_blocked)
  );

  assign periph_addr  = cpu_addr;
  assign periph_wdata = cpu_wdata;
  assign cpu_rdata    = is_ctrl ? DW'(ctl_q) : periph_rdata;

endmodule

// File: rtl/wguard_checker.sv
module wguard_checker #(
  parameter int            AW        = 10,
  parameter logic [AW-1:0] CTRL_ADDR = 10'h078,
  parameter logic [AW-1:0] PDATA_LO  = 10'h000,
  parameter logic [AW-1:0] PDATA_HI  = 10'h00F
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          prog_mode,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_wr,
  input logic          cpu_rd,
  input logic [7:0]    cpu_rdata,
  input logic          periph_wr,
  input logic          periph_rd,
  input logic          wr_blocked,
  input logic [7:0]    ctl_q,
  input logic          port_hit
);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_rd && cpu_addr == CTRL_ADDR) |-> (cpu_rdata[6] == 1'b0 && cpu_rdata[3] == 1'b0));

  p_port_lock_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_wr && port_hit && ctl_q[2]) |-> !periph_wr);

  p_data_pass_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_wr && cpu_addr >= PDATA_LO && cpu_addr <= PDATA_HI) |-> periph_wr);

  p_read_live_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_rd && cpu_addr != CTRL_ADDR) |-> periph_rd);

  p_ctrl_local_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_addr == CTRL_ADDR) |-> (!periph_wr && !periph_rd));

  p_blk_follow_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_wr && cpu_addr != CTRL_ADDR && !periph_wr) |=> wr_blocked);

  p_blk_cause_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_blocked |-> $past(cpu_wr && cpu_addr != CTRL_ADDR && !periph_wr));

  p_prog_clear_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(prog_mode) |-> !ctl_q[0]);

endmodule

bind regbus_write_guard wguard_checker #(.AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .prog_mode  (prog_mode),
  .cpu_addr   (cpu_addr),
  .cpu_wr     (cpu_wr),
  .cpu_rd     (cpu_rd),
  .cpu_rdata  (cpu_rdata),
  .periph_wr  (periph_wr),
  .periph_rd  (periph_rd),
  .wr_blocked (wr_blocked),
  .ctl_q      (ctl_q),
  .port_hit   (hit_vec[wguard_pkg::GB_PORT])
);

// File: tb/tb_regbus_write_guard.sv
module tb_regbus_write_guard;

  localparam logic [9:0] CTRL = 10'h078;

  logic       clk;
  logic       rst_n;
  logic       prog_mode;
  logic [9:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic       cpu_wr;
  logic       cpu_rd;
  logic [7:0] cpu_rdata;
  logic [9:0] periph_addr;
  logic [7:0] periph_wdata;
  logic       periph_wr;
  logic       periph_rd;
  logic [7:0] periph_rdata;
  logic       wr_blocked;

  int nvec;
  int nbad;
  bit done;

  regbus_write_guard dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_mode    (prog_mode),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_wr       (cpu_wr),
    .cpu_rd       (cpu_rd),
    .cpu_rdata    (cpu_rdata),
    .periph_addr  (periph_addr),
    .periph_wdata (periph_wdata),
    .periph_wr    (periph_wr),
    .periph_rd    (periph_rd),
    .periph_rdata (periph_rdata),
    .wr_blocked   (wr_blocked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one bus write to a peripheral address; exp_pass = write must reach peripherals
  task automatic do_wr(input logic [9:0] a, input logic [7:0] d, input bit exp_pass, input string req);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    check({req, " periph_wr"}, periph_wr, exp_pass);
    if (exp_pass) begin
      check({req, " R12 addr"}, periph_addr, a);
      check({req, " R12 data"}, periph_wdata, d);
    end
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    check({req, " R9 blocked pulse"}, wr_blocked, !exp_pass);
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    @(negedge clk);
    cpu_addr = CTRL; cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    check("R8 ctrl write not forwarded", periph_wr, 1'b0);
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    check("R8 ctrl write no blocked pulse", wr_blocked, 1'b0);
  endtask

  task automatic rd_ctrl(input logic [7:0] exp, input string req);
    @(negedge clk);
    cpu_addr = CTRL; cpu_rd = 1'b1;
    #1;
    check(req, cpu_rdata, exp);
    check("R8 ctrl read not forwarded", periph_rd, 1'b0);
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; prog_mode = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    cpu_wr = 1'b0; cpu_rd = 1'b0; periph_rdata = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 blocked low in reset", wr_blocked, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_ctrl(8'h00, "R1 ctrl after reset");
    do_wr(10'h0A0, 8'h11, 1'b1, "R1 clock write after reset");
    do_wr(10'h020, 8'h12, 1'b1, "R1 port write after reset");
  endtask

  task automatic t_ctrl_rw;
    wr_ctrl(8'hFF);
    rd_ctrl(8'hB7, "R2 all ones readback");
    wr_ctrl(8'h48);
    rd_ctrl(8'h00, "R2 reserved bits only");
    wr_ctrl(8'hB0);
    rd_ctrl(8'hB0, "R2 spare bits");
    wr_ctrl(8'h00);
  endtask

  task automatic t_port;
    wr_ctrl(8'h04);
    do_wr(10'h020, 8'hA1, 1'b0, "R3 port low edge");
    do_wr(10'h03F, 8'hA2, 1'b0, "R3 port high edge");
    do_wr(10'h060, 8'hA3, 1'b0, "R3 pin function");
    do_wr(10'h000, 8'hA4, 1'b1, "R4 port data low");
    do_wr(10'h00F, 8'hA5, 1'b1, "R4 port data high");
    do_wr(10'h01F, 8'hA6, 1'b1, "R12 below port group");
    do_wr(10'h040, 8'hA7, 1'b1, "R12 above port group");
    do_wr(10'h0E0, 8'hA8, 1'b1, "R5 irq open while port locked");
    wr_ctrl(8'h07);
    do_wr(10'h005, 8'hA9, 1'b1, "R4 port data all locks");
    wr_ctrl(8'h00);
  endtask

  task automatic t_irq;
    wr_ctrl(8'h02);
    do_wr(10'h0E0, 8'hB1, 1'b0, "R5 irq low");
    do_wr(10'h0EF, 8'hB2, 1'b0, "R5 irq high");
    do_wr(10'h048, 8'hB3, 1'b0, "R5 edge select");
    do_wr(10'h04A, 8'hB4, 1'b1, "R12 past edge select");
    do_wr(10'h020, 8'hB5, 1'b1, "R3 port open while irq locked");
    wr_ctrl(8'h00);
  endtask

  task automatic t_clk;
    wr_ctrl(8'h01);
    do_wr(10'h0A0, 8'hC1, 1'b0, "R6 clock low");
    do_wr(10'h0A9, 8'hC2, 1'b0, "R6 voltage monitor");
    do_wr(10'h0F5, 8'hC3, 1'b0, "R6 parity monitor");
    do_wr(10'h0AA, 8'hC4, 1'b1, "R12 past clock group");
    do_wr(10'h0F4, 8'hC5, 1'b1, "R12 below parity");
    wr_ctrl(8'h00);
  endtask

  task automatic t_read;
    wr_ctrl(8'h07);
    @(negedge clk);
    cpu_addr = 10'h020; cpu_rd = 1'b1; periph_rdata = 8'h5A;
    #1;
    check("R7 read strobe port", periph_rd, 1'b1);
    check("R7 read data port", cpu_rdata, 8'h5A);
    @(negedge clk);
    cpu_addr = 10'h0A0; periph_rdata = 8'hC3;
    #1;
    check("R7 read strobe clock", periph_rd, 1'b1);
    check("R7 read data clock", cpu_rdata, 8'hC3);
    @(negedge clk);
    cpu_rd = 1'b0;
    #1;
    check("R7 no strobe when idle", periph_rd, 1'b0);
  endtask

  task automatic t_ctrl_open;
    // all locks on from t_read
    wr_ctrl(8'h00);
    rd_ctrl(8'h00, "R8 ctrl writable while locked");
    wr_ctrl(8'h07);
    rd_ctrl(8'h07, "R8 ctrl rewritten");
    wr_ctrl(8'h00);
  endtask

  task automatic t_blocked;
    wr_ctrl(8'h04);
    do_wr(10'h030, 8'hD1, 1'b0, "R9 blocked write");
    @(negedge clk);
    #1;
    check("R9 pulse lasts one cycle", wr_blocked, 1'b0);
    // two blocked writes back to back keep the flag high each following cycle
    @(negedge clk);
    cpu_addr = 10'h021; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_addr = 10'h022;
    #1;
    check("R9 back-to-back first", wr_blocked, 1'b1);
    @(negedge clk);
    cpu_wr = 1'b0;
    #1;
    check("R9 back-to-back second", wr_blocked, 1'b1);
    @(negedge clk);
    #1;
    check("R9 back-to-back ends", wr_blocked, 1'b0);
    wr_ctrl(8'h00);
  endtask

  task automatic t_prog;
    // override and software set collide in one cycle
    @(negedge clk);
    prog_mode = 1'b1; cpu_addr = CTRL; cpu_wdata = 8'h01; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    rd_ctrl(8'h00, "R10 set refused in prog mode");
    do_wr(10'h0A0, 8'hE1, 1'b1, "R10 clock write open in prog mode");
    wr_ctrl(8'h07);
    rd_ctrl(8'h06, "R10 other bits kept in prog mode");
    @(negedge clk);
    prog_mode = 1'b0;
    wr_ctrl(8'h07);
    rd_ctrl(8'h07, "R10 set accepted outside prog mode");
    @(negedge clk);
    prog_mode = 1'b1;
    @(negedge clk);
    prog_mode = 1'b0;
    rd_ctrl(8'h06, "R10 stored bit cleared by prog mode");
    do_wr(10'h0A0, 8'hE2, 1'b1, "R10 clock group reopened");
    do_wr(10'h020, 8'hE3, 1'b0, "R10 port lock kept");
    wr_ctrl(8'h00);
  endtask

  task automatic t_timing;
    @(negedge clk);
    cpu_addr = 10'h021; cpu_wdata = 8'hF1; cpu_wr = 1'b1;
    #1;
    check("R11 open before lock", periph_wr, 1'b1);
    @(negedge clk);
    cpu_addr = CTRL; cpu_wdata = 8'h04;
    #1;
    check("R11 ctrl cycle not forwarded", periph_wr, 1'b0);
    @(negedge clk);
    cpu_addr = 10'h021; cpu_wdata = 8'hF2;
    #1;
    check("R11 locked next cycle", periph_wr, 1'b0);
    @(negedge clk);
    cpu_addr = CTRL; cpu_wdata = 8'h00;
    @(negedge clk);
    cpu_addr = 10'h021; cpu_wdata = 8'hF3;
    #1;
    check("R11 unlocked next cycle", periph_wr, 1'b1);
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    nvec = 0; nbad = 0; done = 1'b0;
    t_reset();
    t_ctrl_rw();
    t_port();
    t_irq();
    t_clk();
    t_read();
    t_ctrl_open();
    t_blocked();
    t_prog();
    t_timing();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

endmodule